// File: doc/BRIEF.md
# Streaming Ones'-Complement Checksum Engine with Header Patch

This block computes the 16-bit ones'-complement checksum used by the internet transport protocols while a packet streams into an outboard packet buffer, so that no processor ever reads the payload to build or verify the sum. It holds two independent engines, one per direction, and both can be busy in the same cycle.

On the transmit side the engine watches the word stream that the host-to-buffer DMA writes into packet memory. The request that starts a packet also carries three things: the page that holds the packet, the byte at which summing starts, and the byte offset of the checksum slot in the header. One cycle after the last word, the engine issues a single masked write that patches the inverted, folded sum into that slot in the stored header. On the receive side the engine watches words arriving from the link into packet memory. One cycle after the last word it posts the folded sum and the total packet length, together with a one-cycle done pulse.

Pseudo-header arithmetic is left to software, which adds it to the posted or seeded value.

Top module: `cko_engine`

## Requirements
- R1: While reset is asserted, and until the first packet end, tx_done, mem_wr_en, mem_wr_be, rx_done, rx_sum and rx_len are all zero and tx_cksum reads 0xFFFF.
- R2: tx_cksum is the bitwise inverse of the folded ones'-complement sum of the packet taken as big-endian 16-bit pairs. Byte lane k is data bits [DATA_W-1-8k -: 8], and lane 0 comes first in the packet. The value holds until the next tx_done.
- R3: With an odd count of summed bytes, the final byte forms the high half of a pair whose low half is zero. Lanes of the final word at or above its last-byte count are ignored.
- R4: Packet bytes whose position is below the start offset sampled with the first word add nothing to the sum. The start offset is ignored on all other words.
- R5: tx_done and mem_wr_en each pulse for exactly one cycle, exactly one cycle after the word carrying the end marker is accepted, and at no other time.
- R6: The patch write has word address {page, ins_off >> log2(DATA_W/8)}. The checksum high byte goes to lane ins_off mod (DATA_W/8) and the low byte to the next lane. Exactly those two bits of mem_wr_be are set, and all other data bits are zero. When no write is made, mem_wr_be is zero. Page and ins_off are sampled with the first word.
- R7: rx_done pulses one cycle after the receive end word. rx_sum then holds the folded, non-inverted sum under the rules of R2 to R4. rx_len holds the total byte count, including the excluded leading bytes.
- R8: rx_sum and rx_len change only in a cycle where rx_done is high.
- R9: The two directions run at the same time without affecting each other's results.
- R10: Cycles with the valid input low are ignored, whatever the other inputs carry, including markers and data.
- R11: The host keeps ins_off even and starts the next transmit packet no earlier than the cycle after tx_done. Packets sent at that tightest spacing are still summed and patched correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit word present |
| tx_sop | input | 1 | First word of a transmit packet |
| tx_eop | input | 1 | Last word of a transmit packet |
| tx_data | input | DATA_W | Transmit word, lane 0 in the top byte |
| tx_last_bytes | input | log2(DATA_W/8)+1 | Valid bytes in the last word (1..DATA_W/8) |
| tx_start_off | input | LEN_W | First summed byte, sampled with the first word |
| tx_ins_off | input | PAGE_LOG2 | Byte offset of the checksum slot in the page |
| tx_page | input | PAGE_W | Page holding the packet |
| mem_wr_en | output | 1 | Patch write strobe |
| mem_wr_addr | output | PAGE_W+PAGE_LOG2-log2(DATA_W/8) | Patch word address |
| mem_wr_data | output | DATA_W | Patch data |
| mem_wr_be | output | DATA_W/8 | Patch byte enables, bit k is lane k |
| tx_done | output | 1 | Transmit sum patched |
| tx_cksum | output | 16 | Last inserted checksum |
| rx_valid | input | 1 | Receive word present |
| rx_sop | input | 1 | First word of a receive packet |
| rx_eop | input | 1 | Last word of a receive packet |
| rx_data | input | DATA_W | Receive word, lane 0 in the top byte |
| rx_last_bytes | input | log2(DATA_W/8)+1 | Valid bytes in the last word |
| rx_start_off | input | LEN_W | First summed byte, sampled with the first word |
| rx_done | output | 1 | Receive result posted |
| rx_sum | output | 16 | Folded receive sum |
| rx_len | output | LEN_W | Receive packet length in bytes |

## Verification
Some properties are checked by assertions on every cycle. These are the timing of both done pulses relative to the end markers, the tie between the patch strobe and tx_done, the two-lane shape of the byte enables, and the rule that receive results only move on rx_done. The same checks cover the host-side rules on even slot offsets and transmit start spacing. Whether the sums are numerically right can only be shown by the bench scenarios: odd tails, skipped header bytes, idle gaps with junk, one-word packets and both directions at once. The same holds for where the patch lands in memory. The bench compares these against a byte-queue model of the packet.

// File: rtl/cko_pkg.sv
package cko_pkg;

   // Reduce a plain 32-bit sum of 16-bit pairs to a 16-bit ones'-complement value.
   function automatic logic [15:0] cko_fold32(input logic [31:0] a);
      logic [16:0] s1;
      logic [16:0] s2;
      s1 = {1'b0, a[31:16]} + {1'b0, a[15:0]};
      s2 = {1'b0, s1[15:0]} + {16'd0, s1[16]};
      return s2[15:0];
   endfunction

endpackage

// File: rtl/cko_sum_core.sv
module cko_sum_core
   import cko_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LEN_W    = 16,
   parameter bit KEEP_LEN = 1'b1,
   localparam int LB_W    = $clog2(DATA_W/8) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LB_W-1:0]   in_last_bytes,
   input  logic [LEN_W-1:0]  start_off,
   output logic              done,
   output logic [15:0]       sum_fold,
   output logic [LEN_W-1:0]  pkt_len
);
   localparam int BYTES  = DATA_W / 8;
   localparam int HALVES = DATA_W / 16;
   localparam int WS_W   = 16 + $clog2(HALVES) + 1;
   localparam int AW     = LEN_W + 1;

   logic [LEN_W-1:0] pos_q, start_q, pos_eff, start_eff;
   logic [31:0]      acc_q, acc_nxt;
   logic [WS_W-1:0]  word_sum;
   logic [BYTES-1:0] keep;
   logic [7:0]       lane_byte [BYTES];
   logic             done_q;
   logic [15:0]      sum_q;

   // a new packet restarts position, offset and accumulator in its first word
   assign pos_eff   = in_sop ? '0 : pos_q;
   assign start_eff = in_sop ? start_off : start_q;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [AW-1:0] abs_idx;
      assign abs_idx      = {1'b0, pos_eff} + AW'(b);
      assign keep[b]      = (abs_idx >= {1'b0, start_eff}) &&
                            (!in_eop || (LB_W'(b) < in_last_bytes));
      assign lane_byte[b] = keep[b] ? in_data[DATA_W-1-8*b -: 8] : 8'h00;
   end

   if (HALVES == 1) begin : g_one_pair
      assign word_sum = WS_W'({lane_byte[0], lane_byte[1]});
   end else begin : g_pairs
      always_comb begin
         word_sum = '0;
         for (int h = 0; h < HALVES; h++)
            word_sum = word_sum + WS_W'({lane_byte[2*h], lane_byte[2*h+1]});
      end
   end

   assign acc_nxt = (in_sop ? 32'd0 : acc_q) + 32'(word_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         start_q <= '0;
         acc_q   <= '0;
         done_q  <= 1'b0;
         sum_q   <= '0;
      end else begin
         done_q <= in_valid && in_eop;
         if (in_valid) begin
            acc_q   <= acc_nxt;
            pos_q   <= pos_eff + LEN_W'(BYTES);
            start_q <= start_eff;
            if (in_eop)
               sum_q <= cko_fold32(acc_nxt);
         end
      end
   end

   if (KEEP_LEN) begin : g_len
      logic [LEN_W-1:0] len_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            len_q <= '0;
         else if (in_valid && in_eop)
            len_q <= pos_eff + LEN_W'(in_last_bytes);
      end
      assign pkt_len = len_q;
   end else begin : g_no_len
      assign pkt_len = '0;
   end

   assign done     = done_q;
   assign sum_fold = sum_q;

endmodule

// File: rtl/cko_insert.sv
module cko_insert #(
   parameter int DATA_W    = 32,
   parameter int PAGE_W    = 8,
   parameter int PAGE_LOG2 = 12,
   localparam int BYTES    = DATA_W / 8,
   localparam int LOG_B    = $clog2(BYTES),
   localparam int MAW      = PAGE_W + PAGE_LOG2 - LOG_B
) (
   input  logic                 done,
   input  logic [15:0]          cksum,
   input  logic [PAGE_W-1:0]    page,
   input  logic [PAGE_LOG2-1:0] ins_off,
   output logic                 wr_en,
   output logic [MAW-1:0]       wr_addr,
   output logic [DATA_W-1:0]    wr_data,
   output logic [BYTES-1:0]     wr_be
);
   logic [LOG_B-1:0] hi_lane, lo_lane;

   assign hi_lane = ins_off[LOG_B-1:0];
   assign lo_lane = hi_lane | LOG_B'(1);
   assign wr_en   = done;
   assign wr_addr = {page, ins_off[PAGE_LOG2-1:LOG_B]};

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic hi_sel, lo_sel;
      assign hi_sel = done && (LOG_B'(b) == hi_lane);
      assign lo_sel = done && (LOG_B'(b) == lo_lane);
      assign wr_be[b] = hi_sel || lo_sel;
      assign wr_data[DATA_W-1-8*b -: 8] = hi_sel ? cksum[15:8] :
                                          lo_sel ? cksum[7:0]  : 8'h00;
   end

endmodule

// File: rtl/cko_engine.sv
module cko_engine #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 16,
   parameter int PAGE_W    = 8,
   parameter int PAGE_LOG2 = 12,
   localparam int LB_W     = $clog2(DATA_W/8) + 1,
   localparam int MAW      = PAGE_W + PAGE_LOG2 - $clog2(DATA_W/8)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_valid,
   input  logic                 tx_sop,
   input  logic                 tx_eop,
   input  logic [DATA_W-1:0]    tx_data,
   input  logic [LB_W-1:0]      tx_last_bytes,
   input  logic [LEN_W-1:0]     tx_start_off,
   input  logic [PAGE_LOG2-1:0] tx_ins_off,
   input  logic [PAGE_W-1:0]    tx_page,
   output logic                 mem_wr_en,
   output logic [MAW-1:0]       mem_wr_addr,
   output logic [DATA_W-1:0]    mem_wr_data,
   output logic [DATA_W/8-1:0]  mem_wr_be,
   output logic                 tx_done,
   output logic [15:0]          tx_cksum,
   input  logic                 rx_valid,
   input  logic                 rx_sop,
   input  logic                 rx_eop,
   input  logic [DATA_W-1:0]    rx_data,
   input  logic [LB_W-1:0]      rx_last_bytes,
   input  logic [LEN_W-1:0]     rx_start_off,
   output logic                 rx_done,
   output logic [15:0]          rx_sum,
   output logic [LEN_W-1:0]     rx_len
);
   // elaboration-time parameter checks
   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 16");
   end
   if (LEN_W < 2 || LEN_W > 17) begin : g_bad_len_w
      $error("LEN_W must lie in 2..17 so the 32-bit accumulator cannot wrap");
   end
   if (PAGE_LOG2 <= $clog2(DATA_W/8) || PAGE_LOG2 > LEN_W) begin : g_bad_page
      $error("PAGE_LOG2 must exceed the lane bits and fit in LEN_W");
   end
   if (PAGE_W < 1) begin : g_bad_page_w
      $error("PAGE_W must be at least 1");
   end

   logic [PAGE_W-1:0]    page_q;
   logic [PAGE_LOG2-1:0] ins_q;
   logic                 tx_fin;
   logic [15:0]          tx_raw;
   logic [LEN_W-1:0]     tx_len_unused;

   // request fields are captured with the first transmit word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ins_q  <= '0;
      end else if (tx_valid && tx_sop) begin
         page_q <= tx_page;
         ins_q  <= tx_ins_off;
      end
   end

   cko_sum_core #(
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W),
      .KEEP_LEN (1'b0)
   ) u_tx_sum (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (tx_valid),
      .in_sop        (tx_sop),
      .in_eop        (tx_eop),
      .in_data       (tx_data),
      .in_last_bytes (tx_last_bytes),
      .start_off     (tx_start_off),
      .done          (tx_fin),
      .sum_fold      (tx_raw),
      .pkt_len       (tx_len_unused)
   );

   assign tx_cksum = ~tx_raw;
   assign tx_done  = tx_fin;

   cko_insert #(
      .DATA_W    (DATA_W),
      .PAGE_W    (PAGE_W),
      .PAGE_LOG2 (PAGE_LOG2)
   ) u_patch (
      .done    (tx_fin),
      .cksum   (tx_cksum),
      .page    (page_q),
      .ins_off (ins_q),
      .wr_en   (mem_wr_en),
      .wr_addr (mem_wr_addr),
      .wr_data (mem_wr_data),
      .wr_be   (mem_wr_be)
   );

   cko_sum_core #(
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W),
      .KEEP_LEN (1'b1)
   ) u_rx_sum (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (rx_valid),
      .in_sop        (rx_sop),
      .in_eop        (rx_eop),
      .in_data       (rx_data),
      .in_last_bytes (rx_last_bytes),
      .start_off     (rx_start_off),
      .done          (rx_done),
      .sum_fold      (rx_sum),
      .pkt_len       (rx_len)
   );

endmodule

// File: rtl/cko_engine_chk.sv
module cko_engine_chk #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 16,
   parameter int PAGE_LOG2 = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tx_valid,
   input logic                 tx_sop,
   input logic                 tx_eop,
   input logic [PAGE_LOG2-1:0] tx_ins_off,
   input logic                 tx_done,
   input logic                 mem_wr_en,
   input logic [DATA_W/8-1:0]  mem_wr_be,
   input logic                 rx_valid,
   input logic                 rx_eop,
   input logic                 rx_done,
   input logic [15:0]          rx_sum,
   input logic [LEN_W-1:0]     rx_len
);

   // R5
   tx_done_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_eop) |=> tx_done);

   // R5
   tx_done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && tx_eop) |=> !tx_done);

   // R5
   wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en == tx_done);

   // R6
   wr_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wr_be) == 2));

   // R6
   wr_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_en |-> (mem_wr_be == '0));

   // R7
   rx_done_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_eop) |=> rx_done);

   // R7
   rx_done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_eop) |=> !rx_done);

   // R8
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> ($stable(rx_sum) && $stable(rx_len)));

   // R11
   tx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !(tx_valid && tx_sop));

   // R11
   ins_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_sop) |-> !tx_ins_off[0]);

endmodule

bind cko_engine cko_engine_chk #(
   .DATA_W    (DATA_W),
   .LEN_W     (LEN_W),
   .PAGE_LOG2 (PAGE_LOG2)
) u_chk (.*);

// File: tb/tb_cko_engine.sv
module tb_cko_engine;
   localparam int DW = 32;
   localparam int LW = 16;
   localparam int PW = 8;
   localparam int PL = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid, tx_sop, tx_eop;
   logic [31:0]   tx_data;
   logic [2:0]    tx_last_bytes;
   logic [15:0]   tx_start_off;
   logic [11:0]   tx_ins_off;
   logic [7:0]    tx_page;
   logic          mem_wr_en;
   logic [17:0]   mem_wr_addr;
   logic [31:0]   mem_wr_data;
   logic [3:0]    mem_wr_be;
   logic          tx_done;
   logic [15:0]   tx_cksum;
   logic          rx_valid, rx_sop, rx_eop;
   logic [31:0]   rx_data;
   logic [2:0]    rx_last_bytes;
   logic [15:0]   rx_start_off;
   logic          rx_done;
   logic [15:0]   rx_sum;
   logic [15:0]   rx_len;

   int total = 0;
   int bad = 0;
   bit run_chk = 1'b0;
   string tx_tag = "R2";
   string rx_tag = "R7";
   logic [7:0] tx_buf [0:2047];
   logic [7:0] rx_buf [0:2047];

   always #10 clk = ~clk;

   cko_engine #(.DATA_W(DW), .LEN_W(LW), .PAGE_W(PW), .PAGE_LOG2(PL)) dut (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
      .tx_last_bytes(tx_last_bytes), .tx_start_off(tx_start_off),
      .tx_ins_off(tx_ins_off), .tx_page(tx_page),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_be(mem_wr_be), .tx_done(tx_done), .tx_cksum(tx_cksum),
      .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
      .rx_last_bytes(rx_last_bytes), .rx_start_off(rx_start_off),
      .rx_done(rx_done), .rx_sum(rx_sum), .rx_len(rx_len)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_sum(input logic [7:0] q[$], input int st);
      int unsigned s = 0;
      for (int i = 0; i < q.size(); i += 2) begin
         int unsigned hi = (i >= st) ? int'(q[i]) : 0;
         int unsigned lo = (i + 1 < q.size() && i + 1 >= st) ? int'(q[i+1]) : 0;
         s += hi * 256 + lo;
      end
      while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
      return 16'(s);
   endfunction

   // behavioural reference: byte queues per direction, expected outputs for the next cycle
   logic [7:0]  tq[$];
   logic [7:0]  rq[$];
   int          t_st, t_ins, t_pg, r_st, lane;
   logic        e_tx_done, e_rx_done;
   logic [15:0] e_tx_ck, e_rx_sum, e_rx_len, s_tmp;
   logic [17:0] e_addr;
   logic [31:0] e_data;
   logic [3:0]  e_be;

   always @(posedge clk) begin
      e_tx_done = 1'b0;
      e_rx_done = 1'b0;
      if (!rst_n) begin
         e_tx_ck  = 16'hFFFF;
         e_rx_sum = 16'h0;
         e_rx_len = 16'h0;
      end else begin
         if (tx_valid) begin
            if (tx_sop) begin
               tq.delete();
               t_st  = int'(tx_start_off);
               t_ins = int'(tx_ins_off);
               t_pg  = int'(tx_page);
            end
            for (int l = 0; l < 4; l++)
               if (!tx_eop || l < int'(tx_last_bytes)) tq.push_back(tx_data[31-8*l -: 8]);
            if (tx_eop) begin
               s_tmp     = ref_sum(tq, t_st);
               e_tx_done = 1'b1;
               e_tx_ck   = ~s_tmp;
               e_addr    = 18'(t_pg * 1024 + t_ins / 4);
               lane      = t_ins % 4;
               e_data    = '0;
               e_data[31-8*lane -: 8] = e_tx_ck[15:8];
               e_data[23-8*lane -: 8] = e_tx_ck[7:0];
               e_be      = 4'((1 << lane) | (1 << (lane + 1)));
            end
         end
         if (rx_valid) begin
            if (rx_sop) begin
               rq.delete();
               r_st = int'(rx_start_off);
            end
            for (int l = 0; l < 4; l++)
               if (!rx_eop || l < int'(rx_last_bytes)) rq.push_back(rx_data[31-8*l -: 8]);
            if (rx_eop) begin
               e_rx_done = 1'b1;
               e_rx_sum  = ref_sum(rq, r_st);
               e_rx_len  = 16'(rq.size());
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         chk(tx_done == e_tx_done, "R5 tx_done", 64'(tx_done), 64'(e_tx_done));
         chk(mem_wr_en == e_tx_done, "R5 mem_wr_en", 64'(mem_wr_en), 64'(e_tx_done));
         if (e_tx_done) begin
            chk(tx_cksum == e_tx_ck, {tx_tag, " tx_cksum"}, 64'(tx_cksum), 64'(e_tx_ck));
            chk(mem_wr_addr == e_addr, "R6 mem_wr_addr", 64'(mem_wr_addr), 64'(e_addr));
            chk(mem_wr_data == e_data, "R6 mem_wr_data", 64'(mem_wr_data), 64'(e_data));
            chk(mem_wr_be == e_be, "R6 mem_wr_be", 64'(mem_wr_be), 64'(e_be));
         end else begin
            chk(mem_wr_be == 4'h0, "R6 idle mem_wr_be", 64'(mem_wr_be), 64'h0);
            chk(tx_cksum == e_tx_ck, "R2 tx_cksum hold", 64'(tx_cksum), 64'(e_tx_ck));
         end
         chk(rx_done == e_rx_done, "R7 rx_done", 64'(rx_done), 64'(e_rx_done));
         chk(rx_sum == e_rx_sum, e_rx_done ? {rx_tag, " rx_sum"} : "R8 rx_sum hold",
             64'(rx_sum), 64'(e_rx_sum));
         chk(rx_len == e_rx_len, e_rx_done ? {rx_tag, " rx_len"} : "R8 rx_len hold",
             64'(rx_len), 64'(e_rx_len));
      end
   end

   task automatic tx_pkt(input int n, input int st, input int ins, input int pg, input bit gaps);
      int nw = (n + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] d;
         if (gaps && (w % 2 == 1)) begin
            // R10: idle cycle carrying junk and markers
            tx_valid = 1'b0;
            tx_sop = 1'b1;
            tx_eop = 1'b1;
            tx_data = $urandom;
            tx_last_bytes = 3'($urandom);
            @(negedge clk);
         end
         for (int l = 0; l < 4; l++) begin
            int idx = w * 4 + l;
            d[31-8*l -: 8] = (idx < n) ? tx_buf[idx] : 8'($urandom);
         end
         tx_valid = 1'b1;
         tx_sop = (w == 0);
         tx_eop = (w == nw - 1);
         tx_data = d;
         tx_last_bytes = (w == nw - 1) ? 3'(n - w * 4) : 3'($urandom);
         tx_start_off = (w == 0) ? 16'(st) : 16'($urandom);
         tx_ins_off = (w == 0) ? 12'(ins) : 12'($urandom);
         tx_page = (w == 0) ? 8'(pg) : 8'($urandom);
         @(negedge clk);
      end
      tx_valid = 1'b0;
      tx_sop = 1'b0;
      tx_eop = 1'b0;
      @(negedge clk);
   endtask

   task automatic rx_pkt(input int n, input int st, input bit gaps);
      int nw = (n + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] d;
         if (gaps && (w % 2 == 1)) begin
            rx_valid = 1'b0;
            rx_sop = 1'b1;
            rx_eop = 1'b1;
            rx_data = $urandom;
            rx_last_bytes = 3'($urandom);
            @(negedge clk);
         end
         for (int l = 0; l < 4; l++) begin
            int idx = w * 4 + l;
            d[31-8*l -: 8] = (idx < n) ? rx_buf[idx] : 8'($urandom);
         end
         rx_valid = 1'b1;
         rx_sop = (w == 0);
         rx_eop = (w == nw - 1);
         rx_data = d;
         rx_last_bytes = (w == nw - 1) ? 3'(n - w * 4) : 3'($urandom);
         rx_start_off = (w == 0) ? 16'(st) : 16'($urandom);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_sop = 1'b0;
      rx_eop = 1'b0;
      @(negedge clk);
   endtask

   task automatic fill_tx(input int n);
      for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
   endtask

   task automatic fill_rx(input int n);
      for (int i = 0; i < n; i++) rx_buf[i] = 8'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tx_valid = 0; tx_sop = 0; tx_eop = 0; tx_data = 0; tx_last_bytes = 0;
      tx_start_off = 0; tx_ins_off = 0; tx_page = 0;
      rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = 0; rx_last_bytes = 0; rx_start_off = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_done == 1'b0, "R1 tx_done", 64'(tx_done), 64'h0);
      chk(mem_wr_en == 1'b0, "R1 mem_wr_en", 64'(mem_wr_en), 64'h0);
      chk(mem_wr_be == 4'h0, "R1 mem_wr_be", 64'(mem_wr_be), 64'h0);
      chk(tx_cksum == 16'hFFFF, "R1 tx_cksum", 64'(tx_cksum), 64'hFFFF);
      chk(rx_done == 1'b0, "R1 rx_done", 64'(rx_done), 64'h0);
      chk(rx_sum == 16'h0, "R1 rx_sum", 64'(rx_sum), 64'h0);
      chk(rx_len == 16'h0, "R1 rx_len", 64'(rx_len), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      run_chk = 1'b1;

      // R2 / R7 fixed vector with a hand-computed sum
      tx_buf[0] = 8'h00; tx_buf[1] = 8'h01; tx_buf[2] = 8'hF2; tx_buf[3] = 8'h03;
      tx_buf[4] = 8'hF4; tx_buf[5] = 8'hF5; tx_buf[6] = 8'hF6; tx_buf[7] = 8'hF7;
      for (int i = 0; i < 8; i++) rx_buf[i] = tx_buf[i];
      tx_tag = "R2";
      tx_pkt(8, 0, 16, 3, 1'b0);
      chk(tx_cksum == 16'h220D, "R2 known vector", 64'(tx_cksum), 64'h220D);
      rx_tag = "R7";
      rx_pkt(8, 0, 1'b0);
      chk(rx_sum == 16'hDDF2, "R7 known rx_sum", 64'(rx_sum), 64'hDDF2);
      chk(rx_len == 16'd8, "R7 known rx_len", 64'(rx_len), 64'd8);

      // R3 odd tails and short packets, slot in each even lane
      tx_tag = "R3";
      rx_tag = "R3";
      fill_tx(21); tx_pkt(21, 0, 6, 1, 1'b0);
      fill_tx(3);  tx_pkt(3, 0, 2, 9, 1'b0);
      fill_tx(1);  tx_pkt(1, 0, 4092, 255, 1'b0);
      fill_rx(23); rx_pkt(23, 0, 1'b0);
      fill_rx(1);  rx_pkt(1, 0, 1'b0);

      // R4 leading header bytes excluded, even and odd start positions
      tx_tag = "R4";
      rx_tag = "R4";
      fill_tx(64); tx_pkt(64, 20, 36, 4, 1'b0);
      fill_tx(33); tx_pkt(33, 7, 10, 5, 1'b0);
      fill_rx(60); rx_pkt(60, 14, 1'b0);
      fill_rx(45); rx_pkt(45, 45, 1'b0);

      // R10 idle cycles with junk between words
      tx_tag = "R10";
      rx_tag = "R10";
      fill_tx(50); tx_pkt(50, 12, 26, 6, 1'b1);
      fill_rx(50); rx_pkt(50, 8, 1'b1);

      // R11 tightest transmit spacing, several packets in a row
      tx_tag = "R11";
      for (int k = 0; k < 5; k++) begin
         fill_tx(9 + k * 7);
         tx_pkt(9 + k * 7, k, 2 * k + 40, k + 20, 1'b0);
      end

      // R9 both directions at once
      fork
         begin
            tx_tag = "R9 tx";
            for (int k = 0; k < 6; k++) begin
               fill_tx(30 + k * 11);
               tx_pkt(30 + k * 11, 2 * k, 4 * k + 2, 100 + k, k[0]);
            end
         end
         begin
            rx_tag = "R9 rx";
            for (int k = 0; k < 6; k++) begin
               fill_rx(25 + k * 13);
               rx_pkt(25 + k * 13, k, k[1]);
            end
         end
      join

      // long packets
      tx_tag = "R2";
      rx_tag = "R7";
      fill_tx(1500); tx_pkt(1500, 34, 50, 77, 1'b0);
      fill_rx(1499); rx_pkt(1499, 34, 1'b0);

      repeat (3) @(negedge clk);
      run_chk = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule